// File: doc/BRIEF.md
# Multi-channel DMA request arbiter

This block decides which of several DMA channels gets the system bus next. Each channel can be requested by a peripheral line or by a software request bit. Each channel's hardware line passes through a programmable polarity stage and a per-channel mask. When any channel is pending, the block raises a bus hold request. It then waits for the bus owner to grant the bus through a hold acknowledge input. When the grant arrives, it latches one winner and drives that channel's acknowledge line, whose active level is also programmable.

The choice among pending channels follows either a fixed order, where the lowest index wins, or a rotating order, where the channel served last drops to the bottom. Once a winner is acknowledged it keeps the bus until a transfer-done strobe arrives, whatever the request lines do in the meantime. A done strobe that comes with a terminal-count flag also retires that channel's software request.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset every mask bit is set, the hold request is low, `active_o` is 0, `active_ch_o` is 0, and every acknowledge line sits at its inactive level. Reset selects active-low acknowledges, so all `dack_o` bits read 1.
- R2: A hardware request on a channel whose mask bit is 1 never raises the hold request.
- R3: An unmasked hardware request that is present at a clock edge in the idle state makes `hrq_o` high after that edge. While a channel is acknowledged, `hrq_o` stays high.
- R4: No acknowledge is driven until `hlda_i` has been sampled high at an edge while `hrq_o` was high. The acknowledge appears after that edge, and at most one channel is acknowledged at any time.
- R5: In fixed mode (`cfg_rotate_i`=0) the pending channel with the lowest index wins. `active_ch_o` then gives the winner's index.
- R6: In rotating mode the search starts at the channel above the one served last, wrapping around. The channel just served therefore has the lowest priority. After reset the search starts at channel 0.
- R7: With `cfg_req_low_i`=0 a peripheral line requests when it is 1. With `cfg_req_low_i`=1 it requests when it is 0. Reset selects the active-high behaviour.
- R8: With `cfg_ack_high_i`=1 the acknowledge of the winner is 1 and the others are 0. With `cfg_ack_high_i`=0 every level is inverted.
- R9: The winner and its acknowledge are held unchanged until `done_i` is sampled high. After that edge the acknowledge is released and `hrq_o` goes low for at least one cycle.
- R10: A pulse on `swreq_set_i[n]` sets a software request for channel n, which ignores the mask and raises `hrq_o` two edges after the pulse. The request survives a done strobe with `tc_i`=0 and is cleared by a done strobe with `tc_i`=1 while channel n is acknowledged.
- R11: If every request goes away while the block waits for `hlda_i`, the hold request is withdrawn after the next edge.
- R12: `cfg_wr_i` loads the three configuration bits and `mask_wr_i` loads the whole mask from `mask_wdata_i`, with bit n masking channel n. Each load takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | NCH | Synchronous peripheral request lines |
| cfg_wr_i | input | 1 | Load strobe for the configuration bits |
| cfg_req_low_i | input | 1 | Request lines active low when 1 |
| cfg_ack_high_i | input | 1 | Acknowledge lines active high when 1 |
| cfg_rotate_i | input | 1 | Rotating priority when 1, fixed when 0 |
| mask_wr_i | input | 1 | Load strobe for the mask |
| mask_wdata_i | input | NCH | New mask value, 1 = channel ignored |
| swreq_set_i | input | NCH | Per-channel software request set pulses |
| hlda_i | input | 1 | Hold acknowledge from the bus owner |
| done_i | input | 1 | Transfer-done strobe for the active channel |
| tc_i | input | 1 | Terminal count flag qualifying `done_i` |
| hrq_o | output | 1 | Bus hold request |
| dack_o | output | NCH | Per-channel acknowledge, polarity per configuration |
| active_o | output | 1 | A channel is currently acknowledged |
| active_ch_o | output | $clog2(NCH) | Index of the acknowledged channel, 0 when none |

## Verification
The checker watches several rules on every cycle:
- at most one acknowledge is asserted;
- an acknowledge starts only after a sampled grant;
- the hold request covers the whole acknowledge period;
- the winner stays put until the done strobe, which ends the acknowledge one edge later;
- an idle block with nothing pending keeps the hold request down;
- a terminal-count done clears the software bit it serves.

Some behaviours only the bench scenarios can show, because they need chosen request patterns and configuration histories:
- which channel wins under fixed or rotating order;
- how the polarity settings reshape the request and acknowledge levels;
- that a mask set at reset suppresses requests;
- that a software request outlives a done strobe without terminal count.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_HOLD = 2'd1,
    ARB_XFER = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_req_front.sv
// Request conditioning: polarity, mask register, software request bits.
module dma_req_front #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq_i,
  input  logic           req_low_i,
  input  logic           mask_wr_i,
  input  logic [NCH-1:0] mask_wdata_i,
  input  logic [NCH-1:0] sw_set_i,
  input  logic [NCH-1:0] sw_clr_i,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] sw_o
);
  logic [NCH-1:0] mask_q, mask_d;
  logic [NCH-1:0] sw_q, sw_d;
  logic [NCH-1:0] hw_req;

  always_comb begin
    mask_d = mask_q;
    if (mask_wr_i) mask_d = mask_wdata_i;
  end

  // a set in the same cycle as a clear wins
  always_comb sw_d = (sw_q & ~sw_clr_i) | sw_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= mask_d;
      sw_q   <= sw_d;
    end
  end

  always_comb begin
    hw_req = dreq_i ^ {NCH{req_low_i}};
    pend_o = (hw_req & ~mask_q) | sw_q;
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/dma_prio_pick.sv
// Combinational circular search starting at start_i.
module dma_prio_pick #(
  parameter int NCH  = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]  req_i,
  input  logic [IDXW-1:0] start_i,
  output logic            any_o,
  output logic [IDXW-1:0] win_o
);
  always_comb begin
    int c;
    any_o = 1'b0;
    win_o = '0;
    for (int i = 0; i < NCH; i++) begin
      c = int'(start_i) + i;
      if (c >= NCH) c = c - NCH;
      if (!any_o && req_i[c]) begin
        any_o = 1'b1;
        win_o = IDXW'(c);
      end
    end
  end
endmodule

// File: rtl/dma_hold_fsm.sv
// Hold/acknowledge handshake, winner latch and rotation pointer.
module dma_hold_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend_any_i,
  input  logic [IDXW-1:0] pick_i,
  input  logic            hlda_i,
  input  logic            done_i,
  input  logic            tc_i,
  input  logic            rotate_i,
  output logic [IDXW-1:0] start_o,
  output logic [IDXW-1:0] win_o,
  output logic            hrq_o,
  output logic            xfer_o,
  output logic [NCH-1:0]  sw_clr_o
);
  localparam logic [IDXW-1:0] LAST_CH = IDXW'(NCH - 1);

  arb_state_e      state_q, state_d;
  logic [IDXW-1:0] win_q, win_d;
  logic [IDXW-1:0] last_q, last_d;
  logic            win_en, last_en;

  always_comb begin
    state_d = state_q;
    win_en  = 1'b0;
    last_en = 1'b0;
    case (state_q)
      ARB_IDLE: if (pend_any_i) state_d = ARB_HOLD;
      ARB_HOLD: begin
        if (!pend_any_i) state_d = ARB_IDLE;
        else if (hlda_i) begin
          state_d = ARB_XFER;
          win_en  = 1'b1;
        end
      end
      ARB_XFER: if (done_i) begin
        state_d = ARB_IDLE;
        last_en = 1'b1;
      end
      default: state_d = ARB_IDLE;
    endcase
    win_d  = win_en  ? pick_i : win_q;
    last_d = last_en ? win_q  : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      win_q   <= '0;
      last_q  <= LAST_CH;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      last_q  <= last_d;
    end
  end

  always_comb begin
    if (!rotate_i)             start_o = '0;
    else if (last_q == LAST_CH) start_o = '0;
    else                       start_o = last_q + 1'b1;
  end

  assign hrq_o  = (state_q != ARB_IDLE);
  assign xfer_o = (state_q == ARB_XFER);
  assign win_o  = win_q;

  always_comb begin
    sw_clr_o = '0;
    if (xfer_o && done_i && tc_i) sw_clr_o = {{(NCH-1){1'b0}}, 1'b1} << win_q;
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH  = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  dreq_i,
  input  logic            cfg_wr_i,
  input  logic            cfg_req_low_i,
  input  logic            cfg_ack_high_i,
  input  logic            cfg_rotate_i,
  input  logic            mask_wr_i,
  input  logic [NCH-1:0]  mask_wdata_i,
  input  logic [NCH-1:0]  swreq_set_i,
  input  logic            hlda_i,
  input  logic            done_i,
  input  logic            tc_i,
  output logic            hrq_o,
  output logic [NCH-1:0]  dack_o,
  output logic            active_o,
  output logic [IDXW-1:0] active_ch_o
);
  logic            req_low_q, ack_high_q, rotate_q;
  logic            req_low_d, ack_high_d, rotate_d;
  logic [NCH-1:0]  pend, sw_q, sw_clr;
  logic            pick_any;
  logic [IDXW-1:0] pick_win, start, win;
  logic            xfer;

  always_comb begin
    req_low_d  = req_low_q;
    ack_high_d = ack_high_q;
    rotate_d   = rotate_q;
    if (cfg_wr_i) begin
      req_low_d  = cfg_req_low_i;
      ack_high_d = cfg_ack_high_i;
      rotate_d   = cfg_rotate_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_low_q  <= 1'b0;
      ack_high_q <= 1'b0;
      rotate_q   <= 1'b0;
    end else begin
      req_low_q  <= req_low_d;
      ack_high_q <= ack_high_d;
      rotate_q   <= rotate_d;
    end
  end

  dma_req_front #(.NCH(NCH)) front_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dreq_i       (dreq_i),
    .req_low_i    (req_low_q),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .sw_set_i     (swreq_set_i),
    .sw_clr_i     (sw_clr),
    .pend_o       (pend),
    .sw_o         (sw_q)
  );

  dma_prio_pick #(.NCH(NCH), .IDXW(IDXW)) pick_i (
    .req_i   (pend),
    .start_i (start),
    .any_o   (pick_any),
    .win_o   (pick_win)
  );

  dma_hold_fsm #(.NCH(NCH), .IDXW(IDXW)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_any_i (pick_any),
    .pick_i     (pick_win),
    .hlda_i     (hlda_i),
    .done_i     (done_i),
    .tc_i       (tc_i),
    .rotate_i   (rotate_q),
    .start_o    (start),
    .win_o      (win),
    .hrq_o      (hrq_o),
    .xfer_o     (xfer),
    .sw_clr_o   (sw_clr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_dack
    assign dack_o[g] = (xfer && (win == IDXW'(g))) ^ ~ack_high_q;
  end

  assign active_o    = xfer;
  assign active_ch_o = xfer ? win : '0;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH  = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hrq_o,
  input logic            hlda_i,
  input logic            done_i,
  input logic            tc_i,
  input logic            active_o,
  input logic [IDXW-1:0] active_ch_o,
  input logic [NCH-1:0]  dack_o,
  input logic            ack_high,
  input logic [NCH-1:0]  pend,
  input logic [NCH-1:0]  sw,
  input logic [NCH-1:0]  sw_set
);
  assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o ^ {NCH{~ack_high}}));

  assert_dack_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> ($past(hlda_i) && $past(hrq_o)));

  assert_hrq_covers_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> hrq_o);

  assert_winner_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !done_i) |=> (active_o && $stable(active_ch_o)));

  assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && done_i) |=> (!active_o && !hrq_o));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrq_o && (pend == '0)) |=> !hrq_o);

  assert_sw_retired_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && done_i && tc_i && !sw_set[active_ch_o]) |=> !sw[$past(active_ch_o)]);
endmodule

bind dma_req_arbiter dma_arb_chk #(.NCH(NCH), .IDXW(IDXW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .hrq_o       (hrq_o),
  .hlda_i      (hlda_i),
  .done_i      (done_i),
  .tc_i        (tc_i),
  .active_o    (active_o),
  .active_ch_o (active_ch_o),
  .dack_o      (dack_o),
  .ack_high    (ack_high_q),
  .pend        (pend),
  .sw          (sw_q),
  .sw_set      (swreq_set_i)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] dreq, mask_wdata, sw_set;
  logic       cfg_wr, cfg_req_low, cfg_ack_high, cfg_rotate, mask_wr;
  logic       hlda, done, tc;
  logic       hrq, active;
  logic [3:0] dack;
  logic [1:0] active_ch;

  int nchk = 0;
  int nfail = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .cfg_wr_i(cfg_wr),
    .cfg_req_low_i(cfg_req_low), .cfg_ack_high_i(cfg_ack_high),
    .cfg_rotate_i(cfg_rotate), .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
    .swreq_set_i(sw_set), .hlda_i(hlda), .done_i(done), .tc_i(tc),
    .hrq_o(hrq), .dack_o(dack), .active_o(active), .active_ch_o(active_ch)
  );

  // behavioural reference model
  int       m_st, m_win, m_last;
  bit [3:0] m_mask, m_sw, m_pend, m_clr;
  bit       m_rl, m_ah, m_rot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_win = 0; m_last = 3; m_mask = 4'hF; m_sw = 0;
      m_rl = 0; m_ah = 0; m_rot = 0;
    end else begin
      int first, pick;
      m_pend = ((dreq ^ {4{m_rl}}) & ~m_mask) | m_sw;
      first = m_rot ? (m_last + 1) % 4 : 0;
      pick = -1;
      for (int k = 0; k < 4; k++)
        if (pick < 0 && m_pend[(first + k) % 4]) pick = (first + k) % 4;
      m_clr = 0;
      if (m_st == 0) begin
        if (m_pend != 0) m_st = 1;
      end else if (m_st == 1) begin
        if (m_pend == 0) m_st = 0;
        else if (hlda) begin m_st = 2; m_win = pick; end
      end else if (done) begin
        if (tc) m_clr[m_win] = 1'b1;
        m_last = m_win;
        m_st = 0;
      end
      m_sw = (m_sw & ~m_clr) | sw_set;
      if (mask_wr) m_mask = mask_wdata;
      if (cfg_wr) begin m_rl = cfg_req_low; m_ah = cfg_ack_high; m_rot = cfg_rotate; end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) if (rst_n) begin
    logic [3:0] ed;
    ed = ((m_st == 2) ? (4'b0001 << m_win) : 4'b0000) ^ (m_ah ? 4'h0 : 4'hF);
    check("R3 model hrq", {31'b0, hrq}, {31'b0, m_st != 0});
    check("R4 R8 model dack", {28'b0, dack}, {28'b0, ed});
    check("R5 model active_ch", {30'b0, active_ch}, (m_st == 2) ? m_win : 0);
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 0; dreq = 0; mask_wdata = 0; sw_set = 0; cfg_wr = 0;
    cfg_req_low = 0; cfg_ack_high = 0; cfg_rotate = 0; mask_wr = 0;
    hlda = 0; done = 0; tc = 0;
    cyc(3); rst_n = 1; cyc(1);
    check("R1 hrq", {31'b0, hrq}, 0);
    check("R1 dack", {28'b0, dack}, 4'hF);
    check("R1 active_ch", {30'b0, active_ch}, 0);
    // R2: all lines high, reset mask blocks them
    dreq = 4'hF; cyc(3);
    check("R2 hrq masked", {31'b0, hrq}, 0);
    // R12: unmask channel 2 only
    mask_wr = 1; mask_wdata = 4'b1011; cyc(1); mask_wr = 0;
    cyc(1);
    check("R3 hrq raised", {31'b0, hrq}, 1);
    check("R4 no dack before hlda", {28'b0, dack}, 4'hF);
    cyc(2);
    check("R4 still waiting", {28'b0, dack}, 4'hF);
    hlda = 1; cyc(1);
    check("R4 R8 dack low ch2", {28'b0, dack}, 4'b1011);
    check("R5 active_ch 2", {30'b0, active_ch}, 2);
    // R9: unmasking more channels does not move the winner
    mask_wr = 1; mask_wdata = 4'b0000; cyc(1); mask_wr = 0; cyc(1);
    check("R9 winner held", {28'b0, dack}, 4'b1011);
    done = 1; tc = 1; cyc(1); done = 0; tc = 0;
    check("R9 released hrq", {31'b0, hrq}, 0);
    check("R9 released dack", {28'b0, dack}, 4'hF);
    cyc(2);
    check("R5 fixed lowest ch0", {30'b0, active_ch}, 0);
    done = 1; dreq = 4'b1010; cyc(1); done = 0;
    cyc(2);
    check("R5 fixed picks ch1", {30'b0, active_ch}, 1);
    // R6: switch to rotating at the done edge
    done = 1; cfg_wr = 1; cfg_rotate = 1; cyc(1); done = 0; cfg_wr = 0;
    cyc(2);
    check("R6 rotate after ch1 -> ch3", {30'b0, active_ch}, 3);
    done = 1; cyc(1); done = 0;
    cyc(2);
    check("R6 rotate after ch3 -> ch1", {30'b0, active_ch}, 1);
    done = 1; dreq = 4'h0; cyc(1); done = 0;
    // R7/R8: active-low requests, active-high acks
    mask_wr = 1; mask_wdata = 4'hF; cfg_wr = 1; cfg_req_low = 1;
    cfg_ack_high = 1; cfg_rotate = 0; cyc(1); mask_wr = 0; cfg_wr = 0;
    dreq = 4'hF; mask_wr = 1; mask_wdata = 4'h0; cyc(1); mask_wr = 0;
    cyc(2);
    check("R7 high lines idle when active low", {31'b0, hrq}, 0);
    check("R8 inactive acks low", {28'b0, dack}, 4'h0);
    dreq = 4'b1101; cyc(2);
    check("R7 low line requests ch1", {30'b0, active_ch}, 1);
    check("R8 dack high ch1", {28'b0, dack}, 4'b0010);
    done = 1; tc = 1; dreq = 4'hF; cyc(1); done = 0; tc = 0;
    // R11: request withdrawn before grant
    hlda = 0; dreq = 4'b1110; cyc(1);
    check("R11 hrq up", {31'b0, hrq}, 1);
    dreq = 4'hF; cyc(1);
    check("R11 hrq withdrawn", {31'b0, hrq}, 0);
    // R10: software request bypasses the mask
    mask_wr = 1; mask_wdata = 4'hF; cyc(1); mask_wr = 0;
    sw_set = 4'b1000; cyc(1); sw_set = 0; cyc(1);
    check("R10 sw raises hrq", {31'b0, hrq}, 1);
    hlda = 1; cyc(1);
    check("R10 sw served ch3", {28'b0, dack}, 4'b1000);
    done = 1; tc = 0; cyc(1); done = 0;
    cyc(1);
    check("R10 sw kept without tc", {31'b0, hrq}, 1);
    cyc(1);
    check("R10 sw reserved ch3", {30'b0, active_ch}, 3);
    done = 1; tc = 1; cyc(1); done = 0; tc = 0;
    cyc(3);
    check("R10 sw cleared by tc", {31'b0, hrq}, 0);
    report();
  end
endmodule